// File: doc/BRIEF.md
# Supervisory Reset Controller with Service Watchdog

This block produces the system reset for a small processor subsystem. It combines three reset causes into a single output. The first is an undervoltage flag from an external comparator that already has hysteresis. The second is an active-low push-button style manual reset. The third is a watchdog, which the processor keeps alive by changing the level of a service line. While any cause is present the output stays in its detection state. Once every cause has cleared, the output is held in that state for a selectable release delay and then released.

All timing is derived from one internal tick of nominally 125 µs, produced by a prescaler from the clock frequency parameter. A scale-down parameter shortens the tick so that simulations stay short. The release delay and the watchdog timeout are picked by static select inputs, and both are counted in ticks. A level change on the service line only counts once the new level has been stable for more than 300 ns. Build parameters set the output polarity and can leave out the watchdog entirely.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `uv_i` is high the output is in the detection state. The output enters that state no more than 3 clock cycles after `uv_i` rises.
- R2: While `mr_n_i` is low the output is in the detection state. The output enters that state no more than 3 clock cycles after `mr_n_i` falls.
- R3: After the last cause clears, the output is released once the release delay has been counted. The delay is 2 synchronizer cycles plus N ticks. A tick lasts max(1, CLK_HZ/(8000*SCALE_DOWN)) clocks. N depends on `rel_sel_i`: 0→25, 1→200, 2→400, 3→800, 4→1600, 5→3200, and 6 or 7→12800.
- R4: In the released state with the watchdog enabled, the output enters the detection state if no edge is accepted on `wd_i` for M ticks. M depends on `wd_sel_i`: 0→50, 1→400, 2→800, 3→1600, 4→3200, and 5 to 7→12800.
- R5: A rising or a falling accepted edge on `wd_i` restarts the watchdog count from zero.
- R6: A level change on `wd_i` is accepted only after the new level has been held for F = max(2, CLK_HZ*3/10^7 + 1) clocks. A shorter excursion has no effect.
- R7: Every watchdog expiry is followed by one full release delay, and then the output is released. The watchdog count is held at zero throughout the detection state, so it starts from zero after each release.
- R8: While `wd_en_i` is low the watchdog never expires, and its count is held at zero.
- R9: With HAS_WDOG=0 only `uv_i` and `mr_n_i` can place the output in the detection state.
- R10: With ACTIVE_LOW=1 the output is 0 in detection and 1 when released. With ACTIVE_LOW=0 these levels are inverted.
- R11: During `rst` the output is in the detection state. After `rst` falls with no cause present, the output is released one release delay later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_i | input | 1 | Undervoltage flag, high when supply is low |
| mr_n_i | input | 1 | Manual reset, active low |
| wd_i | input | 1 | Watchdog service line, toggled by software |
| wd_en_i | input | 1 | Watchdog enable, low models a floating service pin |
| rel_sel_i | input | 3 | Release delay select |
| wd_sel_i | input | 3 | Watchdog timeout select |
| rst_out_o | output | 1 | Reset output, polarity set by ACTIVE_LOW |

## Verification
The bench uses CLK_HZ=20 MHz and SCALE_DOWN=2500, so one tick equals one clock and the stable-level filter needs 7 clocks. With these values even the 200-tick delay and the 400-tick timeout finish in a few hundred cycles, which lets the bench predict every output edge to the exact cycle. A second instance shares the same inputs but is built active-high and without the watchdog. This exposes the polarity and the no-watchdog variant while the first instance goes through watchdog expiries.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int TICK_HZ = 8000;
    localparam int TICK_W  = 14;

    typedef logic [TICK_W-1:0] ticks_t;

    typedef enum logic [0:0] {
        ST_DETECT  = 1'b0,
        ST_RELEASE = 1'b1
    } sup_state_e;

    typedef struct packed {
        logic uv;
        logic mr_n;
        logic wd;
        logic wd_en;
    } sup_in_t;

    function automatic ticks_t rel_ticks(input logic [2:0] sel);
        case (sel)
            3'd0:    return ticks_t'(25);
            3'd1:    return ticks_t'(200);
            3'd2:    return ticks_t'(400);
            3'd3:    return ticks_t'(800);
            3'd4:    return ticks_t'(1600);
            3'd5:    return ticks_t'(3200);
            default: return ticks_t'(12800);
        endcase
    endfunction

    function automatic ticks_t wd_ticks(input logic [2:0] sel);
        case (sel)
            3'd0:    return ticks_t'(50);
            3'd1:    return ticks_t'(400);
            3'd2:    return ticks_t'(800);
            3'd3:    return ticks_t'(1600);
            3'd4:    return ticks_t'(3200);
            default: return ticks_t'(12800);
        endcase
    endfunction

    function automatic int div_calc(input int clk_hz, input int scale);
        int q;
        q = clk_hz / (TICK_HZ * scale);
        return (q < 1) ? 1 : q;
    endfunction

    function automatic int filt_calc(input int clk_hz);
        longint q;
        q = (longint'(clk_hz) * 3) / 10_000_000 + 1;
        return (q < 2) ? 2 : int'(q);
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            q_o      <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            q_o      <= stage1_q;
        end
    end
endmodule

// File: rtl/sup_prescaler.sv
module sup_prescaler #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_bypass
            logic unused_pre;
            assign unused_pre = clk ^ rst;
            assign tick_o     = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pc_q;

            assign tick_o = (pc_q == PW'(DIV - 1));

            always_ff @(posedge clk) begin
                if (rst || tick_o) pc_q <= '0;
                else               pc_q <= pc_q + PW'(1);
            end

            // R3: ticks are spaced, never back to back when dividing
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/sup_wd_filter.sv
module sup_wd_filter #(
    parameter int FILT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic svc_o
);
    localparam int FW = $clog2(FILT + 1);

    logic          lvl_q;
    logic [FW-1:0] run_q;
    logic          differ;

    assign differ = (raw_i != lvl_q);
    assign svc_o  = differ && (run_q == FW'(FILT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (!differ) begin
            run_q <= '0;
        end else if (svc_o) begin
            lvl_q <= raw_i;
            run_q <= '0;
        end else begin
            run_q <= run_q + FW'(1);
        end
    end

    // R6: an accepted edge needs the line to have been steady beforehand
    p_filter_stable_r6: assert property (@(posedge clk) disable iff (rst)
        svc_o |-> ($past(raw_i) == raw_i));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog import sup_pkg::*; #(
    parameter bit HAS = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   run_i,
    input  logic   svc_i,
    input  ticks_t limit_i,
    output logic   expire_o
);
    generate
        if (HAS) begin : g_wd
            ticks_t cnt_q;
            logic   at_lim;

            assign at_lim   = (cnt_q == limit_i - ticks_t'(1));
            assign expire_o = run_i && !svc_i && tick_i && at_lim;

            always_ff @(posedge clk) begin
                if (rst || !run_i || svc_i || expire_o) cnt_q <= '0;
                else if (tick_i)                        cnt_q <= cnt_q + ticks_t'(1);
            end

            // R7: no counting outside the running state
            p_wd_cleared_r7: assert property (@(posedge clk) disable iff (rst)
                !run_i |=> (cnt_q == '0));
            // R5: a service restarts the count
            p_service_restart_r5: assert property (@(posedge clk) disable iff (rst)
                svc_i |=> (cnt_q == '0));
        end else begin : g_nowd
            logic unused_nowd;
            assign unused_nowd = ^{clk, rst, tick_i, run_i, svc_i, limit_i};
            assign expire_o    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sup_release_fsm.sv
module sup_release_fsm import sup_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       cause_i,
    input  logic       expire_i,
    input  ticks_t     delay_i,
    output sup_state_e state_o
);
    sup_state_e st_q;
    ticks_t     cnt_q;
    ticks_t     last_cnt;

    assign last_cnt = delay_i - ticks_t'(1);
    assign state_o  = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_DETECT;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_DETECT: begin
                    if (cause_i) begin
                        cnt_q <= '0;
                    end else if (tick_i) begin
                        if (cnt_q == last_cnt) begin
                            st_q  <= ST_RELEASE;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + ticks_t'(1);
                        end
                    end
                end
                default: begin
                    if (cause_i || expire_i) begin
                        st_q  <= ST_DETECT;
                        cnt_q <= '0;
                    end
                end
            endcase
        end
    end

    // R1: a present cause always leads to detection
    p_cause_detect_r1: assert property (@(posedge clk) disable iff (rst)
        cause_i |=> (st_q == ST_DETECT));
    // R3: release happens only after the full count
    p_release_count_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_RELEASE) |-> ($past(cnt_q) == $past(last_cnt)));
    // R4: watchdog expiry forces detection
    p_expiry_detect_r4: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> (st_q == ST_DETECT));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl import sup_pkg::*; #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int SCALE_DOWN = 1,
    parameter bit ACTIVE_LOW = 1'b1,
    parameter bit HAS_WDOG   = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       uv_i,
    input  logic       mr_n_i,
    input  logic       wd_i,
    input  logic       wd_en_i,
    input  logic [2:0] rel_sel_i,
    input  logic [2:0] wd_sel_i,
    output logic       rst_out_o
);
    localparam int DIV  = div_calc(CLK_HZ, SCALE_DOWN);
    localparam int FILT = filt_calc(CLK_HZ);

    sup_in_t    raw_in;
    sup_in_t    syn_in;
    logic [3:0] syn_v;
    logic       tick;
    logic       cause;
    logic       svc;
    logic       wd_run;
    logic       expire;
    logic       released;
    sup_state_e state;

    assign raw_in = '{uv: uv_i, mr_n: mr_n_i, wd: wd_i, wd_en: wd_en_i};

    sup_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_v)
    );
    assign syn_in = sup_in_t'(syn_v);

    sup_prescaler #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    sup_wd_filter #(.FILT(FILT)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .raw_i (syn_in.wd),
        .svc_o (svc)
    );

    assign cause    = syn_in.uv | ~syn_in.mr_n;
    assign released = (state == ST_RELEASE);
    assign wd_run   = released && syn_in.wd_en;

    sup_wdog #(.HAS(HAS_WDOG)) u_wd (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .run_i    (wd_run),
        .svc_i    (svc),
        .limit_i  (wd_ticks(wd_sel_i)),
        .expire_o (expire)
    );

    sup_release_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .cause_i  (cause),
        .expire_i (expire),
        .delay_i  (rel_ticks(rel_sel_i)),
        .state_o  (state)
    );

    generate
        if (ACTIVE_LOW) begin : g_low
            assign rst_out_o = released;
        end else begin : g_high
            assign rst_out_o = !released;
        end

        if (HAS_WDOG) begin : g_chk_wd
            // R8: leaving release without a cause needs the enable
            p_en_gates_expiry_r8: assert property (@(posedge clk) disable iff (rst)
                $fell(released) |-> ($past(cause) || $past(syn_in.wd_en)));
        end else begin : g_chk_nowd
            // R9: only the two external causes can end the released state
            p_only_causes_r9: assert property (@(posedge clk) disable iff (rst)
                $fell(released) |-> $past(cause));
        end
    endgenerate

    // R2: a low manual reset keeps the output in detection
    p_manual_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !syn_in.mr_n |=> !released);
endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv = 1'b0, mr_n = 1'b1, wd = 1'b0, wd_en = 1'b0;
    logic [2:0] rel_sel = 3'd0, wd_sel = 3'd0;
    logic       out0, out1;

    int checks = 0, fails = 0, cyc = 0;
    bit prev_det = 1'b1;

    typedef struct { bit det; int lo; int hi; string tag; } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sup_reset_ctrl #(.CLK_HZ(20_000_000), .SCALE_DOWN(2500),
                     .ACTIVE_LOW(1'b1), .HAS_WDOG(1'b1)) u0 (
        .clk(clk), .rst(rst), .uv_i(uv), .mr_n_i(mr_n), .wd_i(wd),
        .wd_en_i(wd_en), .rel_sel_i(rel_sel), .wd_sel_i(wd_sel), .rst_out_o(out0));

    sup_reset_ctrl #(.CLK_HZ(20_000_000), .SCALE_DOWN(2500),
                     .ACTIVE_LOW(1'b0), .HAS_WDOG(1'b0)) u1 (
        .clk(clk), .rst(rst), .uv_i(uv), .mr_n_i(mr_n), .wd_i(wd),
        .wd_en_i(wd_en), .rel_sel_i(rel_sel), .wd_sel_i(wd_sel), .rst_out_o(out1));

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // driver side: expected output edge at nominal cycle nom
    task automatic push(bit det, int nom, string tag);
        exp_t e;
        e.det = det; e.lo = nom - 1; e.hi = nom + 2; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    // monitor: every output edge is matched against the scoreboard
    always @(negedge clk) begin
        bit   d;
        exp_t e;
        if (!rst) begin
            d = !out0;
            if (d != prev_det) begin
                if (q.size() == 0) begin
                    check(1'b0, "R3 unexpected output edge", cyc, -1);
                end else begin
                    e = q.pop_front();
                    check(e.det == d && cyc >= e.lo && cyc <= e.hi, e.tag, cyc, e.lo + 1);
                end
                prev_det = d;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R3 watchdog run did not finish", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t, tl;
        repeat (5) @(negedge clk);
        check(out0 == 1'b0, "R11 detection during reset", out0, 0);
        check(out1 == 1'b1, "R10 active-high detection level", out1, 1);
        rst = 1'b0;
        push(1'b0, cyc + 27, "R11 power-up release");
        drain();
        check(out1 == 1'b0, "R10 active-high released level", out1, 0);

        // undervoltage
        @(negedge clk); uv = 1'b1;
        push(1'b1, cyc + 3, "R1 undervoltage detect");
        repeat (40) @(negedge clk);
        check(out0 == 1'b0, "R1 held while flag high", out0, 0);
        check(out1 == 1'b1, "R10 active-high in detection", out1, 1);
        uv = 1'b0;
        push(1'b0, cyc + 27, "R3 release delay sel 0");
        drain();

        // manual reset
        @(negedge clk); mr_n = 1'b0;
        push(1'b1, cyc + 3, "R2 manual detect");
        repeat (60) @(negedge clk);
        check(out0 == 1'b0, "R2 held while low", out0, 0);
        mr_n = 1'b1;
        push(1'b0, cyc + 27, "R2 manual release");
        drain();

        // longer release delay
        @(negedge clk); rel_sel = 3'd1; uv = 1'b1;
        push(1'b1, cyc + 3, "R1 short pulse detect");
        repeat (5) @(negedge clk);
        uv = 1'b0;
        push(1'b0, cyc + 202, "R3 release delay sel 1");
        drain();
        rel_sel = 3'd0;

        // watchdog expiry, repeated
        @(negedge clk); wd_en = 1'b1; t = cyc;
        push(1'b1, t + 52,  "R4 timeout sel 0");
        push(1'b0, t + 77,  "R7 release after expiry");
        push(1'b1, t + 127, "R7 count restarts from zero");
        push(1'b0, t + 152, "R7 second release");
        while (out0) @(negedge clk);
        check(out1 == 1'b0, "R9 no watchdog in variant", out1, 0);
        drain();

        // servicing with both edge directions
        repeat (10) @(negedge clk);
        tl = cyc;
        for (int i = 0; i < 6; i++) begin
            check(out0 == 1'b1, "R5 serviced output stays released", out0, 1);
            wd = ~wd; tl = cyc;
            repeat (30) @(negedge clk);
        end
        push(1'b1, tl + 59, "R5 timeout from last accepted edge");
        push(1'b0, tl + 84, "R7 release after expiry");
        drain();

        // glitch shorter than the filter
        repeat (10) @(negedge clk);
        wd = ~wd; t = cyc;
        push(1'b1, t + 59, "R6 glitch ignored");
        push(1'b0, t + 84, "R7 release after expiry");
        repeat (20) @(negedge clk);
        wd = ~wd;
        repeat (3) @(negedge clk);
        wd = ~wd;
        drain();

        // enable low
        wd_en = 1'b0;
        repeat (300) @(negedge clk);
        check(out0 == 1'b1, "R8 disabled watchdog never expires", out0, 1);

        // longer timeout
        wd_sel = 3'd1; wd_en = 1'b1; t = cyc;
        push(1'b1, t + 402, "R4 timeout sel 1");
        push(1'b0, t + 427, "R7 release after expiry");
        drain();
        wd_en = 1'b0;
        repeat (200) @(negedge clk);
        check(out0 == 1'b1, "R8 stays released after disable", out0, 1);
        check(out1 == 1'b0, "R9 variant never left release", out1, 0);
        check(q.size() == 0, "R3 scoreboard empty", q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule